// File: doc/BRIEF.md
# Complementary Dead-Band Gate Driver with Latched Trip

This block takes one raw PWM waveform and turns it into two active-high, complementary gate-drive signals, `gateA` and `gateB`. Before either switch may turn on, a programmable dead time must pass. `gateA` turns on only after the raw PWM has been high for a set number of clock cycles. `gateB` turns on only after the raw PWM has been low for a separate set number of cycles. Each signal turns off as soon as the raw PWM leaves its level. The two delays come from two independent inputs, each `DELAY_W` bits wide. With the default width of 10 bits, a dead time of about 1.5 us at 75 MHz (a count of 112 or 113) fits easily.

A protection latch forces both drives low. It can be set by an external trip input or by a software force bit. Software typically sets it at start-up so that the power stage begins switched off. The latch stays set after its source goes away, and it is released only by an explicit clear. While the latch is set, the delay counters are held at zero. After release, each output therefore waits out its full dead time again before it turns on.

Top module: `deadband_trip_gen`

## Requirements
- R1: While `rstN` is low and immediately after reset, `gateA`, `gateB` and `tripFlag` are all 0.
- R2: `gateA` goes to 1 at the (`riseDelay`+1)-th consecutive rising clock edge that samples `pwmIn` high. It returns to 0 after the first edge that samples `pwmIn` low. `riseDelay` = 0 means one cycle of latency.
- R3: `gateB` goes to 1 at the (`fallDelay`+1)-th consecutive rising clock edge that samples `pwmIn` low. It returns to 0 after the first edge that samples `pwmIn` high.
- R4: A raw high pulse sampled on `riseDelay` or fewer edges produces no pulse on `gateA`. A raw low pulse sampled on `fallDelay` or fewer edges produces no pulse on `gateB`.
- R5: `gateA` and `gateB` are never 1 at the same time.
- R6: When `tripIn` or `swForce` is 1, both outputs go to 0 in the same cycle, without waiting for a clock edge. `tripFlag` becomes 1 after the next clock edge.
- R7: Once set, `tripFlag` stays 1, and both outputs stay 0, after `tripIn` and `swForce` return to 0. This lasts until a clock edge samples `tripClear` = 1.
- R8: `tripClear` has no effect at an edge where `tripIn` or `swForce` is also 1, because setting takes priority.
- R9: After the latch is cleared, each output waits out its full delay as counted from the clearing edge, even if `pwmIn` was steady throughout the trip.
- R10: The largest delay value, 2^`DELAY_W`-1, is honoured exactly, with no counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmIn | input | 1 | Raw PWM waveform |
| riseDelay | input | DELAY_W | Dead time before `gateA` turns on, in cycles |
| fallDelay | input | DELAY_W | Dead time before `gateB` turns on, in cycles |
| tripIn | input | 1 | External trip request, active high |
| swForce | input | 1 | Software trip force, active high |
| tripClear | input | 1 | Software latch clear, active high |
| gateA | output | 1 | High-side drive, active high |
| gateB | output | 1 | Low-side drive, active high |
| tripFlag | output | 1 | Trip latch state |

## Verification
The bench counts cycles on both sides of each dead-time boundary, so a design with an off-by-one error in the counter compare would switch one cycle early or late. It also sends raw pulses exactly as long as the delay, which must be swallowed. A design that lets them through would glitch the switch. The trip scenarios check three things:
- the latch holds after its source deasserts, which a level-following trip would fail;
- a clear issued while the force is still active is refused, which a design where clear wins would fail;
- after release the dead time restarts, which a design that keeps counting during the trip would fail by turning a switch on at once.

The largest delay value is also exercised, to catch a counter that wraps.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  // Strobes from the trip control to the delay datapath.
  typedef struct packed {
    logic gateOn;    // 1: outputs may drive; 0: force low and hold counters at zero
    logic pwmLevel;  // qualified raw PWM level
  } ctrlStrobe_t;
endpackage

// File: rtl/dbt_trip_ctrl.sv
module dbt_trip_ctrl
  import dbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwmIn,
  input  logic        tripIn,
  input  logic        swForce,
  input  logic        tripClear,
  output ctrlStrobe_t strobe,
  output logic        tripLatched
);
  logic setReq;
  assign setReq = tripIn | swForce;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          tripLatched <= 1'b0;
    else if (setReq)    tripLatched <= 1'b1;   // set has priority over clear
    else if (tripClear) tripLatched <= 1'b0;
  end

  always_comb begin
    strobe.gateOn   = ~(tripLatched | setReq);
    strobe.pwmLevel = pwmIn;
  end

  // R7: the latch holds until an explicit clear
  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tripLatched && !tripClear) |=> tripLatched);
  // R8: a set source always leaves the latch set, whatever the clear does
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tripIn || swForce) |=> tripLatched);
endmodule

// File: rtl/dbt_delay_path.sv
module dbt_delay_path
  import dbt_pkg::*;
#(
  parameter int DELAY_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DELAY_W-1:0] riseDelay,
  input  logic [DELAY_W-1:0] fallDelay,
  output logic               gateA,
  output logic               gateB
);
  localparam int CNT_W = DELAY_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] chanOut;

  // Channel 0 times the high run (drives A), channel 1 times the low run (drives B).
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic             runLevel;
    logic [CNT_W-1:0] runCnt;
    logic [CNT_W-1:0] limit;

    assign runLevel = (ch == 0) ? strobe.pwmLevel : ~strobe.pwmLevel;
    assign limit    = (ch == 0) ? {1'b0, riseDelay} : {1'b0, fallDelay};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 runCnt <= '0;
      else if (!strobe.gateOn)   runCnt <= '0;
      else if (!runLevel)        runCnt <= '0;
      else if (runCnt != CNT_MAX) runCnt <= runCnt + 1'b1;
    end

    assign chanOut[ch] = strobe.gateOn & (runCnt > limit);
  end

  assign gateA = chanOut[0];
  assign gateB = chanOut[1];

  // R5: complementary outputs never overlap
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(gateA && gateB));
  // R2: a low sample turns A off after the edge
  assert_a_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pwmLevel |=> !gateA);
  // R3: a high sample turns B off after the edge
  assert_b_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pwmLevel |=> !gateB);
endmodule

// File: rtl/deadband_trip_gen.sv
module deadband_trip_gen
  import dbt_pkg::*;
#(
  parameter int DELAY_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwmIn,
  input  logic [DELAY_W-1:0] riseDelay,
  input  logic [DELAY_W-1:0] fallDelay,
  input  logic               tripIn,
  input  logic               swForce,
  input  logic               tripClear,
  output logic               gateA,
  output logic               gateB,
  output logic               tripFlag
);
  ctrlStrobe_t strobe;

  dbt_trip_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pwmIn      (pwmIn),
    .tripIn     (tripIn),
    .swForce    (swForce),
    .tripClear  (tripClear),
    .strobe     (strobe),
    .tripLatched(tripFlag)
  );

  dbt_delay_path #(.DELAY_W(DELAY_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .riseDelay(riseDelay),
    .fallDelay(fallDelay),
    .gateA    (gateA),
    .gateB    (gateB)
  );

  // R7: a latched trip keeps both drives off
  assert_trip_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    tripFlag |-> (!gateA && !gateB));
  // R9: on release both drives are still off (dead time restarts)
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tripFlag) |-> (!gateA && !gateB));
endmodule

// File: tb/deadband_trip_gen_tb_top.sv
module deadband_trip_gen_tb_top;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmIn = 1'b0;
  logic [DW-1:0] riseDelay = '0;
  logic [DW-1:0] fallDelay = '0;
  logic tripIn = 1'b0, swForce = 1'b0, tripClear = 1'b0;
  logic gateA, gateB, tripFlag;

  int checks = 0;
  int fails = 0;
  bit overlapSeen = 1'b0;

  always #4 clk = ~clk;

  deadband_trip_gen #(.DELAY_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn),
    .riseDelay(riseDelay), .fallDelay(fallDelay),
    .tripIn(tripIn), .swForce(swForce), .tripClear(tripClear),
    .gateA(gateA), .gateB(gateB), .tripFlag(tripFlag)
  );

  always @(negedge clk) if (rstN && gateA && gateB) overlapSeen = 1'b1;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    #1;
    chk("R1 gateA in reset", gateA, 0);
    chk("R1 gateB in reset", gateB, 0);
    chk("R1 tripFlag in reset", tripFlag, 0);
    tick(); rstN = 1'b1; tick();
    chk("R1 gateA after reset", gateA, 0);
    chk("R1 tripFlag after reset", tripFlag, 0);
  endtask

  task automatic test_rise(input int d);
    riseDelay = DW'(d);
    pwmIn = 1'b0; repeat (3) tick();
    pwmIn = 1'b1;
    repeat (d) tick();
    chk("R2 gateA before delay", gateA, 0);
    tick();
    chk("R2 gateA at delay", gateA, 1);
    chk("R5 gateB while A on", gateB, 0);
    pwmIn = 1'b0; tick();
    chk("R2 gateA off after low", gateA, 0);
  endtask

  task automatic test_fall(input int d);
    fallDelay = DW'(d);
    pwmIn = 1'b1; repeat (3) tick();
    pwmIn = 1'b0;
    repeat (d) tick();
    chk("R3 gateB before delay", gateB, 0);
    tick();
    chk("R3 gateB at delay", gateB, 1);
    pwmIn = 1'b1; tick();
    chk("R3 gateB off after high", gateB, 0);
  endtask

  task automatic test_short_pulse();
    int aHigh = 0;
    int bHigh = 0;
    riseDelay = DW'(6); fallDelay = DW'(4);
    pwmIn = 1'b0; repeat (8) tick();
    pwmIn = 1'b1;
    for (int i = 0; i < 6; i++) begin tick(); if (gateA) aHigh++; end
    pwmIn = 1'b0;
    for (int i = 0; i < 4; i++) begin tick(); if (gateB) bHigh++; end
    pwmIn = 1'b1; tick(); if (gateB) bHigh++;
    chk("R4 no pulse on gateA", aHigh, 0);
    chk("R4 no pulse on gateB", bHigh, 0);
  endtask

  task automatic test_trip_latch();
    riseDelay = DW'(2);
    pwmIn = 1'b1; repeat (5) tick();
    chk("R2 gateA on before trip", gateA, 1);
    tripIn = 1'b1; #1;
    chk("R6 gateA forced low at once", gateA, 0);
    chk("R6 tripFlag before edge", tripFlag, 0);
    tick();
    chk("R6 tripFlag set", tripFlag, 1);
    tripIn = 1'b0; repeat (4) tick();
    chk("R7 tripFlag held", tripFlag, 1);
    chk("R7 gateA held low", gateA, 0);
    tripClear = 1'b1; tick(); tripClear = 1'b0;
    chk("R7 tripFlag cleared", tripFlag, 0);
    chk("R9 gateA off at release", gateA, 0);
    repeat (2) tick();
    chk("R9 gateA waits full delay", gateA, 0);
    tick();
    chk("R9 gateA on after delay", gateA, 1);
  endtask

  task automatic test_force_clear_blocked();
    fallDelay = DW'(3);
    pwmIn = 1'b0; repeat (6) tick();
    chk("R3 gateB on before force", gateB, 1);
    swForce = 1'b1; #1;
    chk("R6 gateB forced low at once", gateB, 0);
    tick();
    chk("R6 tripFlag set by force", tripFlag, 1);
    tripClear = 1'b1; tick();
    chk("R8 clear ignored during force", tripFlag, 1);
    chk("R8 gateB still low", gateB, 0);
    swForce = 1'b0; tick(); tripClear = 1'b0;
    chk("R7 clear after force gone", tripFlag, 0);
    repeat (3) tick();
    chk("R9 gateB waits full delay", gateB, 0);
    tick();
    chk("R9 gateB on after delay", gateB, 1);
  endtask

  task automatic test_max_delay();
    riseDelay = '1;
    pwmIn = 1'b0; repeat (3) tick();
    pwmIn = 1'b1;
    repeat ((1 << DW) - 1) tick();
    chk("R10 gateA before max delay", gateA, 0);
    tick();
    chk("R10 gateA at max delay", gateA, 1);
    repeat (1500) tick();
    chk("R10 gateA stays on, no wrap", gateA, 1);
    pwmIn = 1'b0; tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    test_reset();
    test_rise(0);
    test_rise(5);
    test_rise(112);
    test_fall(0);
    test_fall(7);
    test_fall(113);
    test_short_pulse();
    test_trip_latch();
    test_force_clear_blocked();
    test_max_delay();
    chk("R5 no overlap seen", int'(overlapSeen), 0);
    finish_run();
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule